// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt requests into two request lines towards a processor. One line is the normal interrupt and the other is the fast interrupt. Both lines look at the same raw request vector, but each has its own enable mask. Software changes a mask only by writing to a dedicated set word or clear word. Software can also assert or release request 0 on its own, through a soft-set word and a soft-clear word. For each output, software can read both the raw request vector and the enabled (masked) view.

The register window is word-addressed and uses a simple single-cycle bus. Writes take effect at the clock edge where `wr_en` is high. Read data is combinational while `rd_en` is high and shows the state from before any write in the same cycle. Both outputs are registered, so either output can drive a request input of a second instance to build a cascade.

Top module: `dual_irq_ctrl`

## Requirements
- R1: Raw bit n equals input `src_i[n]` for n ≥ 1. Raw bit 0 is `src_i[0]` OR the software request bit. Reading word 1 or word 9 returns the raw vector.
- R2: `irq_o` is registered. At each clock edge it takes the value "raw AND normal mask is nonzero", so it follows an input or mask change one cycle later.
- R3: `fiq_o` behaves like `irq_o`, but with the fast mask in place of the normal mask.
- R4: Word 0 reads raw AND normal mask, and word 8 reads raw AND fast mask. Word 2 reads the normal mask, and word 10 reads the fast mask.
- R5: A write to word 2 ORs `wdata` into the normal mask. A write to word 3 clears the mask bits where `wdata` is 1 and leaves the others unchanged.
- R6: Words 10 and 11 set and clear the fast mask in the same way. Writes to either mask never change the other mask.
- R7: A write to word 4 with `wdata[0]`=1 sets the software request bit, and a write to word 5 with `wdata[0]`=1 clears it. Such writes with `wdata[0]`=0 have no effect. Reading word 4 returns raw bit 0 in bit 0, with all higher bits zero.
- R8: Writes to words 0, 1, 8, 9, 6, 7 and 12 to 15 change no mask, no software bit and no output.
- R9: Reads of words 3, 5, 11, 6, 7 and 12 to 15 return zero, and `rdata` is zero whenever `rd_en` is low.
- R10: A synchronous active-low reset clears both masks, the software bit, `irq_o` and `fiq_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| src_i | input | NUM_SRC | Level-sensitive request inputs |
| wr_en | input | 1 | Write strobe for the word at `addr` |
| rd_en | input | 1 | Read strobe for the word at `addr` |
| addr | input | ADDR_W | Word index into the register window |
| wdata | input | DATA_W | Write data |
| rdata | output | DATA_W | Read data, zero when not reading |
| irq_o | output | 1 | Registered normal interrupt request |
| fiq_o | output | 1 | Registered fast interrupt request |

## Verification
The bench builds the block with its defaults: 32 sources, 32-bit data and a 4-bit word index. With these values the top source bit and the full mask width are exercised, and the unused words 12 to 15 can be reached for the invalid-access checks. Vector patterns place normal and fast masks over overlapping, disjoint and empty parts of the raw vector, so that the two outputs can be seen to disagree. The software request bit is checked with and without the hardware bit 0 active, and the output latency is checked one cycle before and after an input change.

// File: rtl/dic_pkg.sv
// Package: word map and channel layout of the dual-output interrupt controller.
// Assumes word-addressed access. The normal channel sits at words 0..3 and the fast
// channel repeats that layout eight words higher.
package dic_pkg;
    localparam int CHAN_COUNT   = 2;  // normal, fast
    localparam int CHAN_STRIDE  = 8;  // word distance between channel groups
    localparam int OFS_STATUS   = 0;  // masked status (per channel)
    localparam int OFS_RAW      = 1;  // raw level (per channel)
    localparam int OFS_EN_SET   = 2;  // enable set / enable readback
    localparam int OFS_EN_CLR   = 3;  // enable clear
    localparam int WRD_SOFT_SET = 4;  // software request set / readback
    localparam int WRD_SOFT_CLR = 5;  // software request clear
    localparam int CH_NORMAL    = 0;
    localparam int CH_FAST      = 1;
endpackage

// File: rtl/dic_enable_mask.sv
// Module: one enable mask that is changed only by set and clear writes.
// Assumes SET_ADDR != CLR_ADDR and W <= DATA_W. It resets to zero.
module dic_enable_mask #(
    parameter int W        = 32,
    parameter int DATA_W   = 32,
    parameter int ADDR_W   = 4,
    parameter int SET_ADDR = 2,
    parameter int CLR_ADDR = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      wbits,
    output logic [W-1:0]      mask_q
);
    logic hit_set;
    logic hit_clr;

    // Decode which of this mask's two write words is addressed.
    always_comb begin
        hit_set = wr_en && (addr == ADDR_W'(SET_ADDR));
        hit_clr = wr_en && (addr == ADDR_W'(CLR_ADDR));
    end

    // Mask register: OR on set, AND-NOT on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask_q <= '0;
        else if (hit_set) mask_q <= mask_q | wbits;
        else if (hit_clr) mask_q <= mask_q & ~wbits;
    end

    AST_SET_BITS_ON: assert property (@(posedge clk) disable iff (!rst_n)
        hit_set |=> ((mask_q & $past(wbits)) == $past(wbits)));                 // R5
    AST_CLR_BITS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        hit_clr |=> ((mask_q & $past(wbits)) == '0));                           // R5
    AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_set || hit_clr) |=> $stable(mask_q));                             // R8
endmodule

// File: rtl/dic_soft_src.sv
// Module: software request bit for source 0, with set and clear words.
// Assumes only bit 0 of the write data matters. It resets to zero.
module dic_soft_src #(
    parameter int ADDR_W   = 4,
    parameter int SET_ADDR = 4,
    parameter int CLR_ADDR = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wbit0,
    output logic              soft_q
);
    logic do_set;
    logic do_clr;

    // A write acts only when bit 0 is 1.
    always_comb begin
        do_set = wr_en && wbit0 && (addr == ADDR_W'(SET_ADDR));
        do_clr = wr_en && wbit0 && (addr == ADDR_W'(CLR_ADDR));
    end

    // Software request flop.
    always_ff @(posedge clk) begin
        if (!rst_n)      soft_q <= 1'b0;
        else if (do_set) soft_q <= 1'b1;
        else if (do_clr) soft_q <= 1'b0;
    end

    AST_SOFT_RAISED: assert property (@(posedge clk) disable iff (!rst_n)
        do_set |=> soft_q);                                                     // R7
    AST_SOFT_LOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        do_clr |=> !soft_q);                                                    // R7
endmodule

// File: rtl/dic_out_stage.sv
// Module: registered request output for one channel: high when any enabled raw bit is set.
// Assumes raw and mask are stable before the clock edge. It resets low.
module dic_out_stage #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    input  logic [W-1:0] mask,
    output logic         req_q
);
    // Register the reduction so the output is glitch-free and one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |(raw & mask);
    end

    AST_REQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> $past(|raw));                                                 // R2
    AST_REQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mask) == '0) |-> !req_q);                                        // R3
endmodule

// File: rtl/dic_read_mux.sv
// Module: read data selection for the register window.
// Assumes W <= DATA_W. Unlisted and clear-only words read as zero, and so does
// every word while rd_en is low.
module dic_read_mux
    import dic_pkg::*;
#(
    parameter int W      = 32,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 4
) (
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [W-1:0]      raw,
    input  logic [W-1:0]      en_norm,
    input  logic [W-1:0]      en_fast,
    output logic [DATA_W-1:0] rdata
);
    localparam int FB = CHAN_STRIDE;  // fast channel base word

    logic [W-1:0] sel;
    logic         sel_bit0;

    // Pick the word contents. Word 4 is handled as a single bit.
    always_comb begin
        sel      = '0;
        sel_bit0 = 1'b0;
        if (rd_en) begin
            case (int'(addr))
                OFS_STATUS:      sel = raw & en_norm;
                OFS_RAW:         sel = raw;
                OFS_EN_SET:      sel = en_norm;
                WRD_SOFT_SET:    sel_bit0 = raw[0];
                FB + OFS_STATUS: sel = raw & en_fast;
                FB + OFS_RAW:    sel = raw;
                FB + OFS_EN_SET: sel = en_fast;
                default:         sel = '0;
            endcase
        end
    end

    // Zero-extend the selection to the bus width.
    always_comb begin
        rdata          = '0;
        rdata[W-1:0]   = sel;
        rdata[0]       = sel[0] | sel_bit0;
    end
endmodule

// File: rtl/dual_irq_ctrl.sv
// Module: top level of the dual-output level interrupt controller.
// Assumes a single-cycle word-addressed bus with ADDR_W >= 4 and
// NUM_SRC <= DATA_W. Both outputs are registered so they can drive another instance.
module dual_irq_ctrl
    import dic_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    output logic               irq_o,
    output logic               fiq_o
);
    logic [NUM_SRC-1:0]                 raw;
    logic                               soft_q;
    logic [CHAN_COUNT-1:0][NUM_SRC-1:0] en_q;
    logic [CHAN_COUNT-1:0]              req_q;

    // Raw vector: the hardware inputs, with the software request ORed into bit 0.
    always_comb begin
        raw    = src_i;
        raw[0] = src_i[0] | soft_q;
    end

    dic_soft_src #(
        .ADDR_W  (ADDR_W),
        .SET_ADDR(WRD_SOFT_SET),
        .CLR_ADDR(WRD_SOFT_CLR)
    ) u_soft (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .addr  (addr),
        .wbit0 (wdata[0]),
        .soft_q(soft_q)
    );

    // One mask and one output stage per channel, laid out CHAN_STRIDE words apart.
    for (genvar ch = 0; ch < CHAN_COUNT; ch++) begin : g_chan
        localparam int BASE = ch * CHAN_STRIDE;

        dic_enable_mask #(
            .W       (NUM_SRC),
            .DATA_W  (DATA_W),
            .ADDR_W  (ADDR_W),
            .SET_ADDR(BASE + OFS_EN_SET),
            .CLR_ADDR(BASE + OFS_EN_CLR)
        ) u_mask (
            .clk   (clk),
            .rst_n (rst_n),
            .wr_en (wr_en),
            .addr  (addr),
            .wbits (wdata[NUM_SRC-1:0]),
            .mask_q(en_q[ch])
        );

        dic_out_stage #(
            .W(NUM_SRC)
        ) u_out (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (raw),
            .mask (en_q[ch]),
            .req_q(req_q[ch])
        );
    end

    dic_read_mux #(
        .W     (NUM_SRC),
        .DATA_W(DATA_W),
        .ADDR_W(ADDR_W)
    ) u_rd (
        .rd_en  (rd_en),
        .addr   (addr),
        .raw    (raw),
        .en_norm(en_q[CH_NORMAL]),
        .en_fast(en_q[CH_FAST]),
        .rdata  (rdata)
    );

    // Map the channel outputs onto the named ports.
    always_comb begin
        irq_o = req_q[CH_NORMAL];
        fiq_o = req_q[CH_FAST];
    end

    AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == '0));                                              // R9
    AST_SOFT_SHOWS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_q && rd_en && addr == ADDR_W'(OFS_RAW)) |-> rdata[0]);            // R1
endmodule

// File: tb/dual_irq_ctrl_test.sv
// Bench: vector walk over mask/source patterns, then directed tests.
module dual_irq_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int NS = 32;
    localparam int DW = 32;
    localparam int AW = 4;
    localparam int NVEC = 6;
    // Each entry: {sources, normal mask, fast mask}.
    localparam logic [3*NS-1:0] VEC [NVEC] = '{
        {32'h0000_00F0, 32'h0000_0030, 32'h0000_0C00},
        {32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
        {32'h0000_0000, 32'hFFFF_FFFF, 32'hFFFF_FFFF},
        {32'h1234_5678, 32'h0000_0008, 32'h0000_0200},
        {32'hFFFF_FFFF, 32'h0000_0000, 32'h0001_0000},
        {32'h0F0F_0F0F, 32'hF0F0_F0F0, 32'h0000_0F00}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NS-1:0] src_i = '0;
    logic wr_en = 1'b0;
    logic rd_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic irq_o, fiq_o;
    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    dual_irq_ctrl #(.NUM_SRC(NS), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .src_i(src_i), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .fiq_o(fiq_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Called just after a negedge: one-cycle write.
    task automatic wr(input int a, input logic [DW-1:0] d);
        wr_en = 1'b1; addr = AW'(a); wdata = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] d);
        rd_en = 1'b1; addr = AW'(a);
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic step();
        @(posedge clk); @(negedge clk);
    endtask

    initial begin
        repeat (400000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] d;
        logic [NS-1:0] s, im, fm;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk("R10 irq_o", DW'(irq_o), 0);
        chk("R10 fiq_o", DW'(fiq_o), 0);
        rd(2, d);  chk("R10 normal mask", d, 0);
        rd(10, d); chk("R10 fast mask", d, 0);
        rd(4, d);  chk("R10 soft bit", d, 0);

        // Vector walk: R1 R2 R3 R4
        for (int i = 0; i < NVEC; i++) begin
            {s, im, fm} = VEC[i];
            wr(3, '1); wr(11, '1);
            wr(2, im); wr(10, fm);
            src_i = s;
            step();
            rd(1, d); chk("R1 raw word1", d, s);
            rd(9, d); chk("R1 raw word9", d, s);
            rd(0, d); chk("R4 normal status", d, s & im);
            rd(8, d); chk("R4 fast status", d, s & fm);
            rd(2, d); chk("R4 normal mask read", d, im);
            rd(10, d); chk("R4 fast mask read", d, fm);
            chk("R2 irq_o", DW'(irq_o), DW'(|(s & im)));
            chk("R3 fiq_o", DW'(fiq_o), DW'(|(s & fm)));
        end

        // R2 latency: output holds until the next edge
        wr(3, '1); wr(11, '1); src_i = '0; step();
        wr(2, 32'h0000_0100); step();
        chk("R2 idle before input", DW'(irq_o), 0);
        src_i = 32'h0000_0100;
        #1 chk("R2 not yet updated", DW'(irq_o), 0);
        step();
        chk("R2 updated after one edge", DW'(irq_o), 1);
        chk("R3 fiq unaffected", DW'(fiq_o), 0);
        src_i = '0; step();

        // R5: OR set and partial clear
        wr(3, '1);
        wr(2, 32'h0000_000F); wr(2, 32'h00F0_0000);
        rd(2, d); chk("R5 set accumulates", d, 32'h00F0_000F);
        wr(3, 32'h0010_0005);
        rd(2, d); chk("R5 partial clear", d, 32'h00E0_000A);
        // R6: fast mask independent
        wr(11, '1); wr(10, 32'hA000_0001);
        rd(2, d); chk("R6 normal kept after fast write", d, 32'h00E0_000A);
        wr(11, 32'h2000_0000);
        rd(10, d); chk("R6 fast partial clear", d, 32'h8000_0001);
        rd(2, d); chk("R6 normal kept after fast clear", d, 32'h00E0_000A);

        // R7: software bit 0
        src_i = '0;
        wr(4, 32'hFFFF_FFFE);
        rd(4, d); chk("R7 set with bit0=0 ignored", d, 0);
        wr(4, 32'h1);
        rd(4, d); chk("R7 soft set read", d, 1);
        rd(1, d); chk("R1 soft shows in raw", d, 1);
        step();
        chk("R7 soft drives fiq_o", DW'(fiq_o), 1);
        wr(5, 32'hFFFF_FFFE);
        rd(4, d); chk("R7 clear with bit0=0 ignored", d, 1);
        wr(5, 32'h1);
        rd(4, d); chk("R7 soft cleared", d, 0);
        src_i = 32'h1;
        rd(4, d); chk("R1 hardware bit0 in word4", d, 1);
        src_i = '0;
        wr(4, 32'h1);

        // R8: writes to status and unused words change nothing
        foreach (d[k]) begin end
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 1 || a == 6 || a == 7 || a == 8 || a == 9 || a >= 12)
                wr(a, '0);
        end
        for (int a = 0; a < 16; a++) begin
            if (a == 0 || a == 1 || a == 6 || a == 7 || a == 8 || a == 9 || a >= 12)
                wr(a, '1);
        end
        rd(2, d);  chk("R8 normal mask unchanged", d, 32'h00E0_000A);
        rd(10, d); chk("R8 fast mask unchanged", d, 32'h8000_0001);
        rd(4, d);  chk("R8 soft bit unchanged", d, 1);
        step();
        chk("R8 fiq_o unchanged", DW'(fiq_o), 1);
        chk("R8 irq_o unchanged", DW'(irq_o), 0);

        // R9: clear-only and unused words read zero
        src_i = '1;
        for (int a = 3; a < 16; a++) begin
            if (a == 3 || a == 5 || a == 6 || a == 7 || a == 11 || a >= 12) begin
                rd(a, d); chk($sformatf("R9 word %0d reads zero", a), d, 0);
            end
        end
        chk("R9 idle bus zero", rdata, 0);

        // R10: reset again clears state
        rst_n = 1'b0; step(); rst_n = 1'b1; src_i = '0; @(negedge clk);
        chk("R10 fiq_o after reset", DW'(fiq_o), 0);
        rd(4, d);  chk("R10 soft after reset", d, 0);
        rd(10, d); chk("R10 fast mask after reset", d, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule